// File: doc/BRIEF.md
# Four-Lane Carry Lookahead Unit

This is a combinational lookahead network for four adjacent bit lanes. Each lane supplies a propagate flag and a generate flag. The propagate flag is the OR of that lane's two operand bits, and the generate flag is their AND. A carry enters the lowest lane. From these inputs the unit forms, in parallel, the carries into lanes 1, 2 and 3. Each carry is one flat AND-OR network, so it is two gate levels deep whatever its position.

A flat equation for the carry leaving lane 3 would need an AND and an OR of five inputs. That breaks a four-input fan-in budget. The unit therefore also emits a group propagate and a group generate for the whole four-lane span. An upper tier combines these group flags. Because the group flags have the same meaning as the lane flags, the same module serves unchanged as that upper tier: it takes four group pairs plus the global carry-in and returns the seed carries for the lower units. An auxiliary carry-out is built from the group flags as group generate OR (group propagate AND carry-in), which stays within the fan-in budget. The unit holds no clock and no state.

Top module: `cla4_lookahead`

## Requirements
- R1: `carry_mid[0]` (the carry into lane 1) equals `lane_gen[0] | (lane_prop[0] & carry_in)`.
- R2: `carry_mid[1]` (the carry into lane 2) equals `lane_gen[1] | lane_prop[1]&lane_gen[0] | lane_prop[1]&lane_prop[0]&carry_in`.
- R3: `carry_mid[2]` (the carry into lane 3) equals the four-term sum of products over lanes 0 to 2 and `carry_in`: g2, p2·g1, p2·p1·g0, p2·p1·p0·cin.
- R4: `grp_prop` is 1 exactly when all four `lane_prop` bits are 1.
- R5: `grp_gen` equals g3 | p3·g2 | p3·p2·g1 | p3·p2·p1·g0. `carry_in` plays no part in it.
- R6: `carry_out` equals `grp_gen | (grp_prop & carry_in)`. This is the carry leaving lane 3.
- R7: When lane flags come from operand nibbles A and B (p = A|B, g = A&B), `carry_mid[k-1]` is bit k of A[k-1:0] + B[k-1:0] + carry_in for k = 1..3. `carry_out` is bit 4 of A + B + carry_in.
- R8: Changing only `carry_in` leaves `grp_prop` and `grp_gen` unchanged, for every combination of lane flags.
- R9: Every output is a pure function of the present inputs. When all inputs are 0, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| lane_prop | input | 4 | Per-lane propagate flags; bit i belongs to lane i |
| lane_gen | input | 4 | Per-lane generate flags; bit i belongs to lane i |
| carry_in | input | 1 | Carry entering lane 0 |
| carry_mid | output | 3 | Carries into lanes 1, 2, 3 (bit k-1 is the carry into lane k) |
| grp_prop | output | 1 | Group propagate for the four-lane span |
| grp_gen | output | 1 | Group generate for the four-lane span |
| carry_out | output | 1 | Carry leaving lane 3, formed from the group flags |

## Verification
Whenever the inputs are known, the assertions check that each output carry agrees with one ripple step from its neighbour. They also check that the group flags are consistent with the carry-out: group generate forces it, and group propagate passes the carry-in through. These relations hold between outputs of separate networks, so they catch a term missing from any one of them. The assertions cannot show that the group flags ignore `carry_in` (R8), nor that the carries agree with real nibble addition (R7). Only the bench's sweeps can show these. The first sweep covers all 512 combinations of lane flags and carry-in. The second derives the flags from every pair of operand nibbles and compares against the arithmetic sum.

// File: rtl/cla_pkg.sv
// Package: cla_pkg
// Shared constants for the lookahead network.
// Assumes: one lookahead span never exceeds the gate fan-in budget.
package cla_pkg;
    // Largest number of inputs a single AND or OR gate may take.
    localparam int unsigned CLA_FANIN = 4;
    // Lanes per lookahead span; a span of N lanes needs N+1 product terms
    // for its flat carry-out, so the carry-out is routed via group flags.
    localparam int unsigned CLA_LANES = CLA_FANIN;
endpackage

// File: rtl/cla_sop_chain.sv
// Module: cla_sop_chain
// Forms the carry leaving a span of SPAN lanes as one flat sum of products:
// each lane's generate ANDed with every propagate above it, plus the seed
// carry ANDed with all propagates. Two gate levels, no feedback.
// Assumes: SPAN + 1 <= fan-in budget, so every AND and the OR stay legal.
module cla_sop_chain #(
    parameter int unsigned SPAN = 4
) (
    input  logic [SPAN-1:0] prop,
    input  logic [SPAN-1:0] gen,
    input  logic            seed,
    output logic            chain_out
);
    localparam int unsigned TERMS = SPAN + 1;

    logic [TERMS-1:0] term;

    // One product term per lane: the lane's generate, masked by all higher propagates.
    generate
        for (genvar j = 0; j < SPAN; j++) begin : g_term
            if (j == SPAN - 1) begin : g_top
                assign term[j] = gen[j];
            end else begin : g_masked
                assign term[j] = gen[j] & (&prop[SPAN-1:j+1]);
            end
        end
    endgenerate

    // Seed term: the incoming carry survives only if every lane propagates.
    assign term[SPAN] = seed & (&prop);

    // Second level: OR of all product terms.
    assign chain_out = |term;
endmodule

// File: rtl/cla_group_reduce.sv
// Module: cla_group_reduce
// Collapses LANES propagate/generate pairs into one group pair that an
// upper lookahead tier treats exactly like a single lane's pair.
// Assumes: LANES <= fan-in budget; the group generate must not see any carry.
module cla_group_reduce #(
    parameter int unsigned LANES = cla_pkg::CLA_LANES
) (
    input  logic [LANES-1:0] prop,
    input  logic [LANES-1:0] gen,
    output logic             grp_prop,
    output logic             grp_gen
);
    // Group propagate: a carry crosses the span only if every lane passes it.
    assign grp_prop = &prop;

    // Group generate: same flat network as a carry, with the seed tied low.
    cla_sop_chain #(
        .SPAN (LANES)
    ) u_gen_chain (
        .prop      (prop),
        .gen       (gen),
        .seed      (1'b0),
        .chain_out (grp_gen)
    );
endmodule

// File: rtl/cla4_lookahead.sv
// Module: cla4_lookahead
// Lookahead unit for one four-lane span. It produces the carries into
// lanes 1..LANES-1 in parallel, the group propagate/generate pair, and a
// carry-out built from the group pair. Fed with group pairs instead of lane
// pairs, the same module acts as the upper tier and yields seed carries.
// Assumes: purely combinational use, no clock or reset; LANES <= fan-in budget.
module cla4_lookahead #(
    parameter int unsigned LANES = cla_pkg::CLA_LANES
) (
    input  logic [LANES-1:0] lane_prop,
    input  logic [LANES-1:0] lane_gen,
    input  logic             carry_in,
    output logic [LANES-2:0] carry_mid,
    output logic             grp_prop,
    output logic             grp_gen,
    output logic             carry_out
);
    // Internal carries: carry into lane k is a flat network over lanes 0..k-1.
    generate
        for (genvar k = 1; k < LANES; k++) begin : g_carry
            cla_sop_chain #(
                .SPAN (k)
            ) u_chain (
                .prop      (lane_prop[k-1:0]),
                .gen       (lane_gen[k-1:0]),
                .seed      (carry_in),
                .chain_out (carry_mid[k-1])
            );
        end
    endgenerate

    // Group pair for the next tier up.
    cla_group_reduce #(
        .LANES (LANES)
    ) u_group (
        .prop     (lane_prop),
        .gen      (lane_gen),
        .grp_prop (grp_prop),
        .grp_gen  (grp_gen)
    );

    // Carry-out through the group pair: two-input gates, within budget.
    assign carry_out = grp_gen | (grp_prop & carry_in);
endmodule

// File: rtl/cla4_lookahead_checker.sv
// Module: cla4_lookahead_checker
// Checks the ripple relation between neighbouring carry outputs, and the
// consistency of the group pair with the carry-out.
// Assumes: the default four-lane configuration; checks run only on known inputs.
module cla4_lookahead_checker (
    input logic [3:0] lane_prop,
    input logic [3:0] lane_gen,
    input logic       carry_in,
    input logic [2:0] carry_mid,
    input logic       grp_prop,
    input logic       grp_gen,
    input logic       carry_out
);
    logic inputs_known;
    assign inputs_known = !$isunknown({lane_prop, lane_gen, carry_in});

    // Each carry must be one ripple step from the carry below it.
    always_comb begin
        if (inputs_known) begin
            p_first_step_r1: assert (carry_mid[0] == (lane_gen[0] | (lane_prop[0] & carry_in)));
            p_second_step_r2: assert (carry_mid[1] == (lane_gen[1] | (lane_prop[1] & carry_mid[0])));
            p_third_step_r3: assert (carry_mid[2] == (lane_gen[2] | (lane_prop[2] & carry_mid[1])));
            p_out_step_r6: assert (carry_out == (lane_gen[3] | (lane_prop[3] & carry_mid[2])));
        end
    end

    // Group flags must agree with the carry-out they summarise.
    always_comb begin
        if (inputs_known) begin
            p_gen_forces_out_r5: assert (!grp_gen || carry_out);
            p_prop_passes_in_r4: assert (!grp_prop || (carry_out == (grp_gen | carry_in)));
            p_prop_needs_mid_r4: assert (!(grp_prop && carry_in) || (&carry_mid));
        end
    end
endmodule

bind cla4_lookahead cla4_lookahead_checker u_chk (
    .lane_prop (lane_prop),
    .lane_gen  (lane_gen),
    .carry_in  (carry_in),
    .carry_mid (carry_mid),
    .grp_prop  (grp_prop),
    .grp_gen   (grp_gen),
    .carry_out (carry_out)
);

// File: tb/cla4_lookahead_bench.sv
// Bench: the driver task applies a vector on a rising edge and queues the
// expected outputs; the monitor pops one item per falling edge and compares.
module cla4_lookahead_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 200000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic [3:0] lane_prop = '0;
    logic [3:0] lane_gen  = '0;
    logic       carry_in  = 1'b0;
    logic [2:0] carry_mid;
    logic       grp_prop;
    logic       grp_gen;
    logic       carry_out;

    cla4_lookahead u_cla4_lookahead (
        .lane_prop (lane_prop),
        .lane_gen  (lane_gen),
        .carry_in  (carry_in),
        .carry_mid (carry_mid),
        .grp_prop  (grp_prop),
        .grp_gen   (grp_gen),
        .carry_out (carry_out)
    );

    typedef struct {
        logic [2:0] mid;
        logic       gp;
        logic       gg;
        logic       co;
        bit         arith;
    } exp_t;

    exp_t sbq[$];
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    // Group outputs seen for the carry_in=0 twin of the current vector (R8).
    logic gp_twin, gg_twin;

    // Counts one comparison and reports a mismatch.
    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h (p=%b g=%b cin=%b)",
                     req, act, exp, lane_prop, lane_gen, carry_in);
        end
    endtask

    // Reference model: bit-serial ripple of the lane flags.
    function automatic exp_t ripple(input logic [3:0] pv, input logic [3:0] gv, input logic cv);
        exp_t e;
        logic c;
        logic c0;
        c = cv;
        c0 = 1'b0;
        for (int i = 0; i < 4; i++) begin
            c  = gv[i] | (pv[i] & c);
            c0 = gv[i] | (pv[i] & c0);
            if (i < 3) e.mid[i] = c;
        end
        e.co = c;
        e.gg = c0;
        e.gp = &pv;
        e.arith = 1'b0;
        return e;
    endfunction

    // Applies lane flags and queues the ripple expectation.
    task automatic drive_flags(input logic [3:0] pv, input logic [3:0] gv, input logic cv);
        @(posedge clk);
        lane_prop <= pv;
        lane_gen  <= gv;
        carry_in  <= cv;
        sbq.push_back(ripple(pv, gv, cv));
    endtask

    // Applies flags derived from operand nibbles and queues arithmetic carries.
    task automatic drive_operands(input logic [3:0] a, input logic [3:0] b, input logic cv);
        exp_t e;
        for (int k = 1; k <= 3; k++) begin
            logic [4:0] s;
            s = 5'({1'b0, a} & ((5'd1 << k) - 5'd1)) + 5'({1'b0, b} & ((5'd1 << k) - 5'd1)) + 5'(cv);
            e.mid[k-1] = s[k];
        end
        begin
            logic [4:0] full;
            full = {1'b0, a} + {1'b0, b} + 5'(cv);
            e.co = full[4];
        end
        e.gp = &(a | b);
        e.gg = ripple(a | b, a & b, 1'b0).gg;
        e.arith = 1'b1;
        @(posedge clk);
        lane_prop <= a | b;
        lane_gen  <= a & b;
        carry_in  <= cv;
        sbq.push_back(e);
    endtask

    // Monitor: compares one queued expectation per falling edge.
    initial begin
        forever begin
            @(negedge clk);
            if (sbq.size() > 0) begin
                exp_t e;
                e = sbq.pop_front();
                if (e.arith) begin
                    chk("R7 lane carries vs nibble sum", {1'b0, carry_mid}, {1'b0, e.mid});
                    chk("R7 carry_out vs nibble sum", {3'b0, carry_out}, {3'b0, e.co});
                end else begin
                    chk("R1 carry into lane 1", {3'b0, carry_mid[0]}, {3'b0, e.mid[0]});
                    chk("R2 carry into lane 2", {3'b0, carry_mid[1]}, {3'b0, e.mid[1]});
                    chk("R3 carry into lane 3", {3'b0, carry_mid[2]}, {3'b0, e.mid[2]});
                    chk("R4 group propagate", {3'b0, grp_prop}, {3'b0, e.gp});
                    chk("R5 group generate", {3'b0, grp_gen}, {3'b0, e.gg});
                    chk("R6 carry_out", {3'b0, carry_out}, {3'b0, e.co});
                    // R8: the cin=1 vector follows its cin=0 twin directly.
                    if (carry_in === 1'b1)
                        chk("R8 group flags ignore carry_in", {2'b0, grp_prop, grp_gen}, {2'b0, gp_twin, gg_twin});
                    else begin
                        gp_twin = grp_prop;
                        gg_twin = grp_gen;
                    end
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Stimulus sequence.
    initial begin
        repeat (2) @(posedge clk);
        rst_n <= 1'b1;
        // R9: idle inputs give all-zero outputs.
        @(negedge clk);
        chk("R9 idle outputs zero", {carry_mid, carry_out}, 4'h0);
        chk("R9 idle group flags zero", {2'b0, grp_prop, grp_gen}, 4'h0);
        // Exhaustive flag sweep: cin=0 then cin=1 for each pair (R1-R6, R8).
        for (int v = 0; v < 256; v++) begin
            drive_flags(v[7:4], v[3:0], 1'b0);
            drive_flags(v[7:4], v[3:0], 1'b1);
        end
        // Operand-derived flags against real addition (R7).
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
                for (int c = 0; c < 2; c++)
                    drive_operands(4'(a), 4'(b), c[0]);
        // R9: return to idle, outputs follow the inputs with no state.
        @(posedge clk);
        lane_prop <= '0;
        lane_gen  <= '0;
        carry_in  <= 1'b0;
        while (sbq.size() > 0) @(posedge clk);
        @(negedge clk);
        chk("R9 outputs back to zero", {carry_mid, carry_out}, 4'h0);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule